// File: doc/BRIEF.md
# Bus Ownership and Target Reset Controller

This controller sits beside a small target processor and lets a supervising master borrow the target's address and data bus, then give it back. It handles two things with one four-state machine: whether the target is held in reset or allowed to run, and whether the master currently owns the bus. The master sends one-cycle commands. The controller drives the target's active-low reset and bus-request lines and watches its active-low bus-acknowledge line. It reports the current state, a busy flag, and two enables for the tri-state drivers that the memory-cycle logic uses.

A bus request that is not acknowledged within a timeout is rolled back to the previous ownership state. The timeout is counted in ticks of a prescaled timebase. A run from the reset-acquired state, or a restart, issues a fixed-width reset pulse to the target. Before the address and data drivers are enabled, the strobe drivers are enabled one cycle earlier, with the strobes held inactive (high). The acknowledge input passes through a two-flop synchronizer before the state machine uses it.

Top module: `bus_owner_ctl`

## Requirements
- R1: After `rst_n` is released, the outputs are: `state` = 0 (RESET), `tgt_rst_n` = 0, `busreq_n` = 1, `strb_oe` = 0, `bus_oe` = 0 and `busy` = 0. The state encodings are RESET=0, RESET_ACQUIRED=1, RUNNING=2, RUNNING_ACQUIRED=3.
- R2: A reset command (`cmd_op` = 0) is accepted in any state and at any time, including while busy. On the next cycle it gives `state` = 0, `tgt_rst_n` = 0, `busreq_n` = 1, both enables low and `busy` low.
- R3: A request (`cmd_op` = 1) in RESET does the following:
  - It drives `busreq_n` low and `tgt_rst_n` high, then waits for acknowledge.
  - On acknowledge it enters RESET_ACQUIRED with the drivers enabled.
  - On timeout it drives `tgt_rst_n` low and `busreq_n` high and stays in RESET.
- R4: A request in RUNNING drives `busreq_n` low and waits for acknowledge. On acknowledge it enters RUNNING_ACQUIRED with the drivers enabled. On timeout it drives `busreq_n` high and stays in RUNNING.
- R5: A release (`cmd_op` = 2) disables both drivers and drives `busreq_n` high.
  - From RESET_ACQUIRED it also drives `tgt_rst_n` low and enters RESET.
  - From RUNNING_ACQUIRED it enters RUNNING.
- R6: A run command (`cmd_op` = 3) behaves as follows:
  - In RESET it drives `tgt_rst_n` high and enters RUNNING.
  - In RESET_ACQUIRED it disables the drivers and pulses `tgt_rst_n` low. It then re-enables the drivers and enters RUNNING_ACQUIRED.
- R7: A restart (`cmd_op` = 4) in RUNNING or RUNNING_ACQUIRED pulses `tgt_rst_n` low and leaves `state` unchanged.
- R8: A machine-cycle command (`cmd_op` = 5) in RUNNING_ACQUIRED runs this sequence:
  - It disables the drivers, drives `busreq_n` high and waits for the synchronized acknowledge to go high.
  - It then drives `busreq_n` low and waits for acknowledge under the normal timeout.
  - On acknowledge it re-enables the drivers and stays in RUNNING_ACQUIRED. On timeout it drives `busreq_n` high and enters RUNNING.
- R9: A request with no acknowledge keeps `busy` high for exactly TICK_CYCLES*TIMEOUT_TICKS clock cycles after the command cycle.
- R10: A reset pulse holds `tgt_rst_n` low for exactly PULSE_CYCLES clock cycles.
- R11: `strb_oe` rises one cycle before `bus_oe` on every acquisition. `bus_oe` is never high unless both `strb_oe` is high and `busreq_n` is low.
- R12: `busy` is high while a wait or pulse sequence runs. While busy, every command except reset is ignored. Commands not listed for the current state, and the unused codes 6 and 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code: 0 reset, 1 request, 2 release, 3 run, 4 restart, 5 machine-cycle |
| busack_n | input | 1 | Active-low bus acknowledge from the target |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| busreq_n | output | 1 | Active-low bus request to the target |
| strb_oe | output | 1 | Enable for the strobe drivers (strobes held inactive) |
| bus_oe | output | 1 | Enable for the address and data drivers |
| state | output | 2 | Current ownership state |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions check the invariants on every cycle:
- the driver enable ordering;
- the dependence of `bus_oe` on both the strobe enable and an asserted bus request;
- the output levels that each settled state must show;
- the effect of a reset command in the cycle after it.

Only the bench scenarios can show which transitions each command causes, the exact timeout and pulse lengths, the rollbacks after a missing acknowledge, and that commands are ignored while busy. It drives these with an acknowledge model that follows the bus request after a delay and can be switched off.

// File: rtl/bus_owner_ctl.sv
module bus_owner_ctl #(
  parameter int TICK_CYCLES   = 12_500_000,
  parameter int TIMEOUT_TICKS = 20,
  parameter int PULSE_CYCLES  = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       busack_n,
  output logic       tgt_rst_n,
  output logic       busreq_n,
  output logic       strb_oe,
  output logic       bus_oe,
  output logic [1:0] state,
  output logic       busy
);
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  localparam logic [1:0] S_RST  = 2'd0;
  localparam logic [1:0] S_RSTA = 2'd1;
  localparam logic [1:0] S_RUN  = 2'd2;
  localparam logic [1:0] S_RUNA = 2'd3;

  localparam logic [2:0] OP_RESET   = 3'd0;
  localparam logic [2:0] OP_REQ     = 3'd1;
  localparam logic [2:0] OP_REL     = 3'd2;
  localparam logic [2:0] OP_RUN     = 3'd3;
  localparam logic [2:0] OP_RESTART = 3'd4;
  localparam logic [2:0] OP_MCYC    = 3'd5;

  typedef enum logic [2:0] {PH_IDLE, PH_WAIT, PH_PULSE, PH_MCHI, PH_ARM} phase_t;

  phase_t          ph;
  logic [1:0]      st;
  logic [1:0]      ack_sync;
  logic [PW-1:0]   pre;
  logic [TW-1:0]   ticks;
  logic [CW-1:0]   pcnt;
  logic            arm_after;
  logic            ack_low, tick_end, timed_out, pulse_end;

  assign ack_low   = ~ack_sync[1];
  assign tick_end  = (pre == PW'(TICK_CYCLES - 1));
  assign timed_out = tick_end && (ticks == TW'(TIMEOUT_TICKS - 1));
  assign pulse_end = (pcnt == CW'(PULSE_CYCLES - 1));
  assign state     = st;
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_sync <= 2'b11;
    else        ack_sync <= {ack_sync[0], busack_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      st        <= S_RST;
      tgt_rst_n <= 1'b0;
      busreq_n  <= 1'b1;
      strb_oe   <= 1'b0;
      bus_oe    <= 1'b0;
      pre       <= '0;
      ticks     <= '0;
      pcnt      <= '0;
      arm_after <= 1'b0;
    end else if (cmd_valid && cmd_op == OP_RESET) begin
      ph        <= PH_IDLE;
      st        <= S_RST;
      tgt_rst_n <= 1'b0;
      busreq_n  <= 1'b1;
      strb_oe   <= 1'b0;
      bus_oe    <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (cmd_valid) begin
          case (cmd_op)
            OP_REQ: if (st == S_RST || st == S_RUN) begin
              busreq_n  <= 1'b0;
              tgt_rst_n <= 1'b1;
              pre       <= '0;
              ticks     <= '0;
              ph        <= PH_WAIT;
            end
            OP_REL: if (st == S_RSTA || st == S_RUNA) begin
              strb_oe  <= 1'b0;
              bus_oe   <= 1'b0;
              busreq_n <= 1'b1;
              if (st == S_RSTA) begin
                tgt_rst_n <= 1'b0;
                st        <= S_RST;
              end else begin
                st <= S_RUN;
              end
            end
            OP_RUN: begin
              if (st == S_RST) begin
                tgt_rst_n <= 1'b1;
                st        <= S_RUN;
              end else if (st == S_RSTA) begin
                strb_oe   <= 1'b0;
                bus_oe    <= 1'b0;
                tgt_rst_n <= 1'b0;
                pcnt      <= '0;
                arm_after <= 1'b1;
                ph        <= PH_PULSE;
              end
            end
            OP_RESTART: if (st == S_RUN || st == S_RUNA) begin
              tgt_rst_n <= 1'b0;
              pcnt      <= '0;
              arm_after <= 1'b0;
              ph        <= PH_PULSE;
            end
            OP_MCYC: if (st == S_RUNA) begin
              strb_oe  <= 1'b0;
              bus_oe   <= 1'b0;
              busreq_n <= 1'b1;
              ph       <= PH_MCHI;
            end
            default: ;
          endcase
        end
        PH_WAIT: begin
          if (ack_low) begin
            st      <= st | 2'd1;
            strb_oe <= 1'b1;
            ph      <= PH_ARM;
          end else if (timed_out) begin
            busreq_n <= 1'b1;
            if (st == S_RST) tgt_rst_n <= 1'b0;
            else             st <= S_RUN;
            ph <= PH_IDLE;
          end else if (tick_end) begin
            pre   <= '0;
            ticks <= ticks + 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        PH_MCHI: if (!ack_low) begin
          busreq_n <= 1'b0;
          pre      <= '0;
          ticks    <= '0;
          ph       <= PH_WAIT;
        end
        PH_PULSE: begin
          if (pulse_end) begin
            tgt_rst_n <= 1'b1;
            if (arm_after) begin
              st      <= S_RUNA;
              strb_oe <= 1'b1;
              ph      <= PH_ARM;
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        PH_ARM: begin
          bus_oe <= 1'b1;
          ph     <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_owner_ctl_chk.sv
module bus_owner_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       tgt_rst_n,
  input logic       busreq_n,
  input logic       strb_oe,
  input logic       bus_oe,
  input logic [1:0] state,
  input logic       busy
);
  AST_OE_NEEDS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> strb_oe); // R11
  AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !busreq_n); // R11
  AST_STRB_LEADS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(strb_oe)); // R11
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> (state == 2'd0 && !tgt_rst_n && busreq_n && !strb_oe && !busy)); // R2
  AST_IDLE_RESET_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !busy) |-> (!tgt_rst_n && busreq_n && !strb_oe)); // R3
  AST_IDLE_RUN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !busy) |-> (tgt_rst_n && busreq_n && !bus_oe)); // R4
  AST_IDLE_OWNED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (state[0] && !busy) |-> (!busreq_n && bus_oe && tgt_rst_n)); // R5
endmodule

bind bus_owner_ctl bus_owner_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .tgt_rst_n(tgt_rst_n), .busreq_n(busreq_n), .strb_oe(strb_oe),
  .bus_oe(bus_oe), .state(state), .busy(busy)
);

// File: tb/tb_bus_owner_ctl.sv
module tb_bus_owner_ctl;
  localparam int TICK = 4;
  localparam int TOUT = 5;
  localparam int PULSE = 3;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic busack_n;
  logic tgt_rst_n, busreq_n, strb_oe, bus_oe, busy;
  logic [1:0] state;
  logic ack_en = 1'b1;
  logic d1 = 1'b1, d2 = 1'b1;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    d1 <= busreq_n;
    d2 <= d1;
  end
  assign busack_n = ack_en ? d2 : 1'b1;

  bus_owner_ctl #(.TICK_CYCLES(TICK), .TIMEOUT_TICKS(TOUT), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busack_n(busack_n), .tgt_rst_n(tgt_rst_n), .busreq_n(busreq_n),
    .strb_oe(strb_oe), .bus_oe(bus_oe), .state(state), .busy(busy)
  );

  // {op[2:0], ack_en, state[1:0], tgt_rst_n, busreq_n, bus_oe}
  localparam logic [8:0] VEC [NV] = '{
    9'b000_1_00_0_1_0, // R2 reset
    9'b010_1_00_0_1_0, // R12 release in RESET ignored
    9'b001_1_01_1_0_1, // R3 request acknowledged
    9'b001_1_01_1_0_1, // R12 request while owned ignored
    9'b011_1_11_1_0_1, // R6 run from RESET_ACQUIRED
    9'b100_1_11_1_0_1, // R7 restart keeps state
    9'b101_1_11_1_0_1, // R8 machine cycle re-acquires
    9'b111_1_11_1_0_1, // R12 unused code 7
    9'b010_1_10_1_1_0, // R5 release to RUNNING
    9'b011_1_10_1_1_0, // R12 run in RUNNING ignored
    9'b001_0_10_1_1_0, // R4 request timeout
    9'b001_1_11_1_0_1, // R4 request acknowledged
    9'b101_0_10_1_1_0, // R8 machine cycle timeout
    9'b000_1_00_0_1_0, // R2 reset
    9'b001_0_00_0_1_0, // R3 request timeout
    9'b011_1_10_1_1_0, // R6 run from RESET
    9'b100_1_10_1_1_0, // R7 restart in RUNNING
    9'b110_1_10_1_1_0, // R12 unused code 6
    9'b101_1_10_1_1_0, // R12 machine cycle in RUNNING ignored
    9'b000_1_00_0_1_0  // R2 reset
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int t_strb, t_bus;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state", state, 0);
    chk("R1", "tgt_rst_n", tgt_rst_n, 0);
    chk("R1", "busreq_n", busreq_n, 1);
    chk("R1", "strb_oe", strb_oe, 0);
    chk("R1", "bus_oe", bus_oe, 0);
    chk("R1", "busy", busy, 0);

    for (int v = 0; v < NV; v++) begin
      ack_en = VEC[v][5];
      send(VEC[v][8:6]);
      settle();
      chk($sformatf("vec%0d", v), "state", state, int'(VEC[v][4:3]));
      chk($sformatf("vec%0d", v), "tgt_rst_n", tgt_rst_n, int'(VEC[v][2]));
      chk($sformatf("vec%0d", v), "busreq_n", busreq_n, int'(VEC[v][1]));
      chk($sformatf("vec%0d", v), "bus_oe", bus_oe, int'(VEC[v][0]));
    end
    ack_en = 1'b1;
    settle();

    // R9 exact timeout length from RESET; R3 reset released during wait
    ack_en = 1'b0;
    send(3'd1);
    chk("R3", "tgt_rst_n during wait", tgt_rst_n, 1);
    n = 0;
    while (busy && n < 500) begin n++; @(negedge clk); end
    chk("R9", "busy cycles", n, TICK * TOUT);
    chk("R3", "tgt_rst_n after timeout", tgt_rst_n, 0);

    // R12 run ignored while busy
    send(3'd1);
    send(3'd3);
    settle();
    chk("R12", "state after ignored run", state, 0);

    // R2 reset aborts a wait
    send(3'd1);
    repeat (4) @(negedge clk);
    send(3'd0);
    chk("R2", "busy after abort", busy, 0);
    chk("R2", "busreq_n after abort", busreq_n, 1);
    chk("R2", "state after abort", state, 0);

    // R11 strobe enable leads bus enable by one cycle
    ack_en = 1'b1;
    settle();
    send(3'd1);
    t_strb = -1;
    t_bus = -1;
    for (int i = 0; i < 60; i++) begin
      if (strb_oe && t_strb < 0) t_strb = i;
      if (bus_oe && t_bus < 0) t_bus = i;
      @(negedge clk);
    end
    chk("R11", "bus_oe lag after strb_oe", t_bus - t_strb, 1);
    chk("R3", "state owned", state, 1);

    // R10 pulse width on run from RESET_ACQUIRED, drivers off during pulse (R6)
    send(3'd3);
    chk("R6", "bus_oe during pulse", bus_oe, 0);
    n = 0;
    while (!tgt_rst_n && n < 100) begin n++; @(negedge clk); end
    chk("R10", "pulse cycles", n, PULSE);
    settle();
    chk("R6", "state after run", state, 3);

    // R10 pulse width on restart; R7 state unchanged
    send(3'd4);
    n = 0;
    while (!tgt_rst_n && n < 100) begin n++; @(negedge clk); end
    chk("R10", "restart pulse cycles", n, PULSE);
    settle();
    chk("R7", "state after restart", state, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule